// File: doc/BRIEF.md
# Sticky Priority Interrupt Identifier

This block sits between a message controller and a processor's interrupt logic. It watches one status-change request and fifteen message-slot requests. It reports which of them is being serviced as a single 8-bit code. The processor reads the code through a read strobe. One interrupt line tells the processor that the code is nonzero.

Once a source is shown, the code is pinned to it. A request of higher priority that arrives later does not displace it. The code changes only after the shown source's request level drops. The code then passes through 00h for one clock cycle. On the following edge the block picks the highest-priority request still pending. The status-change request counts only while its flag is set and at least one of its two enable bits is set. Each slot request is a plain level that software clears in the controller.

Top module: `sppi_irq_ident`

## Requirements
- R1: After reset (synchronous, active-low `rst_n`) the code is 00h and `irq_o` is low. Code 00h means that no interrupt is pending.
- R2: The status-change source is active only when `stat_flag` is high and at least one of `err_ie` and `stat_ie` is high. With both enables low, the flag alone leaves the code at 00h.
- R3: Code values and priority order, highest first: 01h is the status-change source, 02h is message slot 15, and 03h through 10h are slots 1 through 14 in order. Slot s is input bit `slot_req[s-1]`.
- R4: While the code is nonzero and the shown source's request is still high, the code keeps its value, even when higher-priority requests become active.
- R5: When the code is 00h and one or more requests are active, the code takes the highest-priority active source on the next clock edge.
- R6: On the edge after the shown source's request is seen low, the code becomes 00h. On the edge after that, it takes the highest-priority request still active, or it stays 00h if none is active.
- R7: `irq_o` is high exactly when the code is nonzero.
- R8: While `rd_en` is high, `rd_data` carries the current code. While `rd_en` is low, `rd_data` is 00h.
- R9: Asserting `wr_en` changes neither the code nor `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| stat_flag | input | 1 | Status-interrupt flag of the controller |
| err_ie | input | 1 | Error-interrupt enable for the status-change source |
| stat_ie | input | 1 | Status-interrupt enable for the status-change source |
| slot_req | input | 15 | Message-slot request levels; bit s-1 is slot s |
| rd_en | input | 1 | Read strobe for the code |
| wr_en | input | 1 | Write strobe; has no effect on the code |
| rd_data | output | 8 | Current code while `rd_en` is high, otherwise 00h |
| irq_o | output | 1 | Interrupt line to the processor |

## Verification
A wrong held-source selection shows at the ports in two ways. The code drops to 00h while its request is still high, or it stays stuck after its request falls. Either shows one edge after the request change. A wrong priority rank shows as the wrong code on the first edge after requests rise while the code is idle. It also shows on the second edge after a clear. The bench therefore samples the code on each of those exact cycles. A lost stickiness shows as a code that changes in the cycle after a higher-priority request rises.

// File: rtl/sppi_pkg.sv
// Package: shared constants and the rank mapping for the interrupt identifier.
// Assumes slot numbers start at 1 and that rank 0 is reserved for the
// status-change source.
package sppi_pkg;

    // Width of the code presented to the processor.
    localparam int CODE_W = 8;

    // Rank of a message slot in the priority vector (0 = highest).
    // The promoted slot sits right below the status source; the
    // remaining slots follow in ascending slot order.
    function automatic int slot_rank(input int slot, input int promoted);
        if (slot == promoted) begin
            return 1;
        end else if (slot < promoted) begin
            return slot + 1;
        end else begin
            return slot;
        end
    endfunction

endpackage

// File: rtl/sppi_req_gate.sv
// Module: builds the ranked request vector from raw request levels.
// Bit 0 is the gated status-change request, bit 1 the promoted slot,
// then the remaining slots in ascending order. Pure combinational.
// Assumes PROMOTED_SLOT lies in 1..NUM_SLOTS.
module sppi_req_gate #(
    parameter int NUM_SLOTS     = 15,
    parameter int PROMOTED_SLOT = 15
) (
    input  logic                 stat_flag,
    input  logic                 err_ie,
    input  logic                 stat_ie,
    input  logic [NUM_SLOTS-1:0] slot_req,
    output logic [NUM_SLOTS:0]   rank_req
);

    // Status source counts only with its flag and at least one enable.
    assign rank_req[0] = stat_flag & (err_ie | stat_ie);

    // Place each slot request at its rank position.
    for (genvar s = 1; s <= NUM_SLOTS; s++) begin : g_slot
        localparam int RANK = sppi_pkg::slot_rank(s, PROMOTED_SLOT);
        assign rank_req[RANK] = slot_req[s-1];
    end

endmodule

// File: rtl/sppi_prio_enc.sv
// Module: fixed-priority encoder over the ranked request vector.
// Rank 0 wins. Returns a one-hot grant and the code (rank + 1).
// Assumes NSRC + 1 fits in CODE_W bits.
module sppi_prio_enc #(
    parameter int NSRC   = 16,
    parameter int CODE_W = 8
) (
    input  logic [NSRC-1:0]   req,
    output logic              any,
    output logic [NSRC-1:0]   pick_oh,
    output logic [CODE_W-1:0] pick_code
);

    // Scan from lowest priority up so the highest-priority hit is kept.
    always_comb begin : p_scan
        pick_oh   = '0;
        pick_code = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (req[i]) begin
                pick_oh    = '0;
                pick_oh[i] = 1'b1;
                pick_code  = CODE_W'(i + 1);
            end
        end
    end

    // Any request pending at all.
    assign any = |req;

endmodule

// File: rtl/sppi_code_hold.sv
// Module: sticky code register. While idle it loads the encoder result.
// While a source is shown it holds until that source's request drops,
// then it returns to idle for one cycle before the next choice.
// Assumes a synchronous active-low reset and request levels that are
// synchronous to clk.
module sppi_code_hold #(
    parameter int NSRC   = 16,
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   rank_req,
    input  logic              any,
    input  logic [NSRC-1:0]   pick_oh,
    input  logic [CODE_W-1:0] pick_code,
    output logic [CODE_W-1:0] code_q
);

    typedef enum logic {ST_IDLE, ST_SHOW} hold_state_t;

    hold_state_t       state_q;
    logic [NSRC-1:0]   held_oh;
    logic              held_live;

    // Request of the shown source still present.
    assign held_live = |(held_oh & rank_req);

    // Load, hold or release the displayed code.
    always_ff @(posedge clk) begin : p_code
        if (!rst_n) begin
            state_q <= ST_IDLE;
            code_q  <= '0;
            held_oh <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (any) begin
                        state_q <= ST_SHOW;
                        code_q  <= pick_code;
                        held_oh <= pick_oh;
                    end
                end
                ST_SHOW: begin
                    if (!held_live) begin
                        state_q <= ST_IDLE;
                        code_q  <= '0;
                        held_oh <= '0;
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                    code_q  <= '0;
                    held_oh <= '0;
                end
            endcase
        end
    end

    // R4: a live shown source pins the code.
    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (code_q != '0 && held_live) |=> $stable(code_q));

    // R4: never more than one source held.
    assert_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(held_oh));

    // R6: release to idle once the shown request falls.
    assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (code_q != '0 && !held_live) |=> code_q == '0);

    // R6: idle with nothing pending stays idle.
    assert_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (code_q == '0 && rank_req == '0) |=> code_q == '0);

    // R5: the status source wins from idle.
    assert_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (code_q == '0 && rank_req[0]) |=> code_q == CODE_W'(1));

endmodule

// File: rtl/sppi_irq_ident.sv
// Module: top of the sticky priority interrupt identifier. Gates and
// ranks the requests, encodes the winner, holds the shown code and
// drives the interrupt line and the read port.
// Assumes synchronous active-low reset; writes are accepted and ignored.
module sppi_irq_ident #(
    parameter int NUM_SLOTS     = 15,
    parameter int PROMOTED_SLOT = 15
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         stat_flag,
    input  logic                         err_ie,
    input  logic                         stat_ie,
    input  logic [NUM_SLOTS-1:0]         slot_req,
    input  logic                         rd_en,
    input  logic                         wr_en,
    output logic [sppi_pkg::CODE_W-1:0]  rd_data,
    output logic                         irq_o
);

    localparam int NSRC   = NUM_SLOTS + 1;
    localparam int CODE_W = sppi_pkg::CODE_W;

    logic [NSRC-1:0]   rank_req;
    logic              any;
    logic [NSRC-1:0]   pick_oh;
    logic [CODE_W-1:0] pick_code;
    logic [CODE_W-1:0] code_q;

    sppi_req_gate #(
        .NUM_SLOTS     (NUM_SLOTS),
        .PROMOTED_SLOT (PROMOTED_SLOT)
    ) u_gate (
        .stat_flag (stat_flag),
        .err_ie    (err_ie),
        .stat_ie   (stat_ie),
        .slot_req  (slot_req),
        .rank_req  (rank_req)
    );

    sppi_prio_enc #(
        .NSRC   (NSRC),
        .CODE_W (CODE_W)
    ) u_enc (
        .req       (rank_req),
        .any       (any),
        .pick_oh   (pick_oh),
        .pick_code (pick_code)
    );

    sppi_code_hold #(
        .NSRC   (NSRC),
        .CODE_W (CODE_W)
    ) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .rank_req  (rank_req),
        .any       (any),
        .pick_oh   (pick_oh),
        .pick_code (pick_code),
        .code_q    (code_q)
    );

    // Interrupt line follows the registered code.
    assign irq_o = (code_q != '0);

    // Read port returns the code only during a read strobe.
    assign rd_data = rd_en ? code_q : '0;

    // R7: a read during an interrupt never returns the idle code.
    assert_irq_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && irq_o) |-> rd_data != '0);

    // R9: a write while idle with nothing pending leaves the line low.
    assert_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !irq_o && rank_req == '0) |=> !irq_o);

endmodule

// File: tb/sppi_irq_ident_test.sv
// Directed bench: one task per scenario, each checking its own results.
// Inputs are driven at the falling edge, outputs sampled there too.
module sppi_irq_ident_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        stat_flag, err_ie, stat_ie;
    logic [14:0] slot_req;
    logic        rd_en, wr_en;
    logic [7:0]  rd_data;
    logic        irq_o;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    sppi_irq_ident uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .stat_flag (stat_flag),
        .err_ie    (err_ie),
        .stat_ie   (stat_ie),
        .slot_req  (slot_req),
        .rd_en     (rd_en),
        .wr_en     (wr_en),
        .rd_data   (rd_data),
        .irq_o     (irq_o)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cycles <= cycles + 1;

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Read the code through the strobe and check it with the line.
    task automatic expect_code(input string req, input int exp);
        logic [7:0] v;
        rd_en = 1'b1;
        #1;
        v = rd_data;
        rd_en = 1'b0;
        #1;
        check(req, v, exp);
        check({req, " irq"}, irq_o, exp != 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; stat_flag = 0; err_ie = 0; stat_ie = 0;
        slot_req = '0; rd_en = 0; wr_en = 0;
        step(); step();
        rst_n = 1'b1;
        step();
        expect_code("R1", 0);
    endtask

    task automatic t_status_gate();
        stat_flag = 1;
        step(); step();
        expect_code("R2 no enable", 0);
        err_ie = 1;
        step();
        expect_code("R2 err enable", 1);
        stat_flag = 0;
        step();
        expect_code("R2 flag off", 0);
        err_ie = 0; stat_ie = 1; stat_flag = 1;
        step();
        expect_code("R2 stat enable", 1);
        stat_flag = 0; stat_ie = 0;
        step(); step();
        expect_code("R2 cleared", 0);
    endtask

    task automatic t_order();
        for (int s = 1; s <= 15; s++) begin
            slot_req = '0;
            slot_req[s-1] = 1'b1;
            step();
            expect_code("R3", (s == 15) ? 2 : s + 2);
            slot_req = '0;
            step(); step();
        end
        expect_code("R3 idle", 0);
    endtask

    task automatic t_simul();
        slot_req[2] = 1; slot_req[6] = 1; slot_req[14] = 1;
        step();
        expect_code("R5 simultaneous", 8'h02);
        slot_req[14] = 0;
        step();
        expect_code("R6 gap", 0);
        step();
        expect_code("R6 next slot3", 8'h05);
        slot_req[2] = 0;
        step(); step();
        expect_code("R6 next slot7", 8'h09);
        slot_req[6] = 0;
        step(); step();
        expect_code("R6 none left", 0);
    endtask

    task automatic t_sticky();
        slot_req[13] = 1;
        step();
        expect_code("R3 lowest", 8'h10);
        stat_flag = 1; stat_ie = 1; slot_req[14] = 1;
        for (int k = 0; k < 3; k++) begin
            step();
            expect_code("R4 sticky", 8'h10);
        end
        slot_req[13] = 0;
        step();
        expect_code("R6 gap", 0);
        step();
        expect_code("R6 status next", 1);
        stat_flag = 0; stat_ie = 0;
        step(); step();
        expect_code("R6 slot15 next", 2);
        slot_req[14] = 0;
        step(); step();
        expect_code("R6 drained", 0);
    endtask

    task automatic t_read_write();
        wr_en = 1;
        step();
        wr_en = 0;
        expect_code("R9 idle write", 0);
        slot_req[0] = 1;
        step();
        wr_en = 1;
        step(); step();
        wr_en = 0;
        expect_code("R9 write held", 3);
        #1;
        check("R8 no strobe", rd_data, 0);
        check("R7 line", irq_o, 1);
        slot_req[0] = 0;
        step(); step();
        expect_code("R8 end", 0);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures",
                 n_checks, n_fails);
        $finish;
    endtask

    initial begin
        t_reset();
        t_status_gate();
        t_order();
        t_simul();
        t_sticky();
        t_read_write();
        finish_run();
    end

    initial begin
        wait (cycles > 5000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: got %0d cycles expected under 5000", cycles);
        finish_run();
    end

endmodule